// File: doc/BRIEF.md
# Boundary-Scan Test Access Controller

This block is the serial test port of a chip. It is clocked by a test clock and steered by a mode-select line, and it takes a serial data input and drives a serial data output. It holds the sixteen-state test controller, a 4-bit instruction register with its decoder, a single-bit pass-through register, a 32-bit identification word, and a short chain of pin cells. Each pin cell has a shift flip-flop and a parallel hold stage. The power-on reset is an input to the block, so there is no separate reset pin on the test port.

Board test equipment loads an instruction, then scans data through the register that the instruction selects. The decoder sets two outputs for the pad ring. One hands the pins to the hold stages of the chain (test mode). The other floats every output (force-float). Two instructions beyond the usual minimum combine the pass-through register with either force-float or test mode. A second path back to the reset state fires when mode-select and data-in are both high for five test-clock edges in a row.

Top module: `tap_ctrl`

## Requirements
- R1: While `por` is high at a rising `tck` edge, the controller enters Test-Logic-Reset. By the next falling edge the active instruction is IDCODE (0001), and `tdo_en`, `test_mode` and `force_float` are low.
- R2: On each rising `tck` edge the controller follows the standard sixteen-state transition graph, steered by `tms`.
- R3: When `tms` and `tdi` are both high on five consecutive rising `tck` edges, the controller is in Test-Logic-Reset after the fifth edge, and IDCODE becomes the active instruction.
- R4: The instruction shift register loads 0001 in Capture-IR and shifts LSB first, with `tdi` entering at bit 3. The active instruction takes the shifted value on the falling `tck` edge while in Update-IR. In Test-Logic-Reset it is set to IDCODE.
- R5: The decoder maps the instruction codes as follows. 0000 selects the pin chain with `test_mode` high. 0001 selects the identification word. 0010 selects the pin chain with `test_mode` low. 0011 selects the pass-through register with `force_float` high. 0100 selects the pass-through register with `test_mode` high. 1111 selects the pass-through register.
- R6: Any other code, such as 0110, acts exactly like 1111: it selects the pass-through register with `test_mode` and `force_float` low.
- R7: The pass-through register is one bit wide and loads 0 in Capture-DR. Data scanned through it therefore appears on `tdo` one shift later, preceded by a 0.
- R8: With IDCODE active, Capture-DR loads the word {version[3:0], part 16'h2626, maker 11'h001, 1'b1}. With the default version of 1 this word is 32'h12626003, and it shifts out LSB first.
- R9: When the pin chain is selected, Capture-DR loads `sys_in`. Shift-DR moves the chain toward bit 0, with `tdi` entering at the top cell. On the falling edge in Update-DR the hold stages take the shifted bits. `pin_out` equals the hold stages while `test_mode` is high, and equals `core_out` otherwise.
- R10: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is high exactly while the controller is in Shift-IR or Shift-DR, and during those states `tdo` carries bit 0 of the register being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por | input | 1 | Power-on reset, active high, sampled on `tck` |
| tms | input | 1 | Mode select steering the controller |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, valid while `tdo_en` |
| tdo_en | output | 1 | Output enable for the `tdo` pad (low means high-impedance) |
| sys_in | input | BSR_LEN | Pin values captured by the chain |
| core_out | input | BSR_LEN | Functional values the core drives toward the pads |
| pin_out | output | BSR_LEN | Values sent to the pads |
| test_mode | output | 1 | Pads take values from the chain's hold stages |
| force_float | output | 1 | All functional outputs to high-impedance |

## Verification
The hardest situation to reach is the five-edge reset on `tms` with `tdi`, because a plain run of `tms` high also ends in Test-Logic-Reset. The stimulus first loads EXTEST so that `test_mode` is visibly high. It then holds both lines high for exactly five edges and checks that `test_mode` drops and that a fresh data scan returns the identification word. The hold stages of the chain are also observable only after a complete capture, shift and update sequence under EXTEST. The bench therefore shifts a pattern chosen to differ from both `sys_in` and `core_out`.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
    } tap_state_e;

    localparam int OP_W = 4;
    localparam logic [OP_W-1:0] OP_EXTEST   = 4'b0000;
    localparam logic [OP_W-1:0] OP_IDCODE   = 4'b0001;
    localparam logic [OP_W-1:0] OP_SAMPLE   = 4'b0010;
    localparam logic [OP_W-1:0] OP_FLOATBYP = 4'b0011;
    localparam logic [OP_W-1:0] OP_TESTBYP  = 4'b0100;
    localparam logic [OP_W-1:0] OP_BYPASS   = 4'b1111;
    localparam logic [OP_W-1:0] OP_CAPT_PAT = 4'b0001;

    typedef enum logic [1:0] {
        DR_PASS,
        DR_IDENT,
        DR_CHAIN
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e sel;
        logic    test_mode;
        logic    force_float;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(input logic [OP_W-1:0] op);
        op_ctrl_t c;
        c = '{sel: DR_PASS, test_mode: 1'b0, force_float: 1'b0};
        case (op)
            OP_EXTEST:   c = '{sel: DR_CHAIN, test_mode: 1'b1, force_float: 1'b0};
            OP_IDCODE:   c = '{sel: DR_IDENT, test_mode: 1'b0, force_float: 1'b0};
            OP_SAMPLE:   c = '{sel: DR_CHAIN, test_mode: 1'b0, force_float: 1'b0};
            OP_FLOATBYP: c = '{sel: DR_PASS,  test_mode: 1'b0, force_float: 1'b1};
            OP_TESTBYP:  c = '{sel: DR_PASS,  test_mode: 1'b1, force_float: 1'b0};
            default:     c = '{sel: DR_PASS,  test_mode: 1'b0, force_float: 1'b0};
        endcase
        return c;
    endfunction

    function automatic tap_state_e step_state(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:    n = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   n = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   n = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: n = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: n = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: n = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: n = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   n = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   n = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   n = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: n = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: n = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: n = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: n = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            default:     n = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import tap_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic       tck,
    input  logic       por,
    input  logic       tms,
    input  logic       tdi,
    output tap_state_e state
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_q;
    logic          both_hi;
    logic          run_done;

    assign both_hi  = tms & tdi;
    assign run_done = both_hi && (run_q == CW'(RUN_LEN - 1));

    always_ff @(posedge tck) begin
        if (por) begin
            state <= ST_RESET;
            run_q <= '0;
        end else if (run_done) begin
            state <= ST_RESET;
            run_q <= '0;
        end else begin
            state <= step_state(state, tms);
            run_q <= both_hi ? run_q + 1'b1 : '0;
        end
    end
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            por,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [OP_W-1:0] ir_shift,
    output logic [OP_W-1:0] ir_active
);
    always_ff @(posedge tck) begin
        if (por) begin
            ir_shift <= '0;
        end else if (state == ST_IR_CAP) begin
            ir_shift <= OP_CAPT_PAT;
        end else if (state == ST_IR_SHIFT) begin
            ir_shift <= {tdi, ir_shift[OP_W-1:1]};
        end
    end

    always_ff @(negedge tck) begin
        if (por || state == ST_RESET) begin
            ir_active <= OP_IDCODE;
        end else if (state == ST_IR_UPD) begin
            ir_active <= ir_shift;
        end
    end
endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
    import tap_pkg::*;
#(
    parameter int          ID_W    = 32,
    parameter logic [31:0] ID_WORD = 32'h1262_6003
) (
    input  logic       tck,
    input  logic       por,
    input  tap_state_e state,
    input  logic       tdi,
    input  dr_sel_e    sel,
    input  logic       chain_lsb,
    output logic       byp_q,
    output logic       dr_lsb
);
    logic [ID_W-1:0] id_q;

    always_ff @(posedge tck) begin
        if (por) begin
            byp_q <= 1'b0;
            id_q  <= '0;
        end else begin
            if (sel == DR_PASS) begin
                if (state == ST_DR_CAP)        byp_q <= 1'b0;
                else if (state == ST_DR_SHIFT) byp_q <= tdi;
            end
            if (sel == DR_IDENT) begin
                if (state == ST_DR_CAP)        id_q <= ID_WORD[ID_W-1:0];
                else if (state == ST_DR_SHIFT) id_q <= {tdi, id_q[ID_W-1:1]};
            end
        end
    end

    always_comb begin
        case (sel)
            DR_IDENT: dr_lsb = id_q[0];
            DR_CHAIN: dr_lsb = chain_lsb;
            default:  dr_lsb = byp_q;
        endcase
    end
endmodule

// File: rtl/tap_bsr_cell.sv
`timescale 1ns/1ps
module tap_bsr_cell (
    input  logic tck,
    input  logic por,
    input  logic cap_en,
    input  logic shf_en,
    input  logic upd_en,
    input  logic pin_in,
    input  logic ser_in,
    input  logic core_d,
    input  logic test_mode,
    output logic ser_out,
    output logic pad_d
);
    logic hold_q;

    always_ff @(posedge tck) begin
        if (por)         ser_out <= 1'b0;
        else if (cap_en) ser_out <= pin_in;
        else if (shf_en) ser_out <= ser_in;
    end

    always_ff @(negedge tck) begin
        if (por)         hold_q <= 1'b0;
        else if (upd_en) hold_q <= ser_out;
    end

    assign pad_d = test_mode ? hold_q : core_d;
endmodule

// File: rtl/tap_bsr.sv
`timescale 1ns/1ps
module tap_bsr
    import tap_pkg::*;
#(
    parameter int LEN = 8
) (
    input  logic           tck,
    input  logic           por,
    input  tap_state_e     state,
    input  logic           tdi,
    input  logic           chain_sel,
    input  logic           test_mode,
    input  logic [LEN-1:0] sys_in,
    input  logic [LEN-1:0] core_out,
    output logic [LEN-1:0] pin_out,
    output logic           chain_lsb
);
    logic [LEN-1:0] ser_q;
    logic           cap_en, shf_en, upd_en;

    assign cap_en = chain_sel && state == ST_DR_CAP;
    assign shf_en = chain_sel && state == ST_DR_SHIFT;
    assign upd_en = chain_sel && state == ST_DR_UPD;

    for (genvar i = 0; i < LEN; i++) begin : g_cell
        logic ser_in;
        if (i == LEN - 1) begin : g_top
            assign ser_in = tdi;
        end else begin : g_mid
            assign ser_in = ser_q[i+1];
        end
        tap_bsr_cell u_cell (
            .tck       (tck),
            .por       (por),
            .cap_en    (cap_en),
            .shf_en    (shf_en),
            .upd_en    (upd_en),
            .pin_in    (sys_in[i]),
            .ser_in    (ser_in),
            .core_d    (core_out[i]),
            .test_mode (test_mode),
            .ser_out   (ser_q[i]),
            .pad_d     (pin_out[i])
        );
    end

    assign chain_lsb = ser_q[0];
endmodule

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
module tap_ctrl
    import tap_pkg::*;
#(
    parameter int          BSR_LEN    = 8,
    parameter int          RUN_LEN    = 5,
    parameter logic [3:0]  ID_VERSION = 4'h1,
    parameter logic [15:0] ID_PART    = 16'h2626,
    parameter logic [10:0] ID_MAKER   = 11'h001
) (
    input  logic               tck,
    input  logic               por,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_en,
    input  logic [BSR_LEN-1:0] sys_in,
    input  logic [BSR_LEN-1:0] core_out,
    output logic [BSR_LEN-1:0] pin_out,
    output logic               test_mode,
    output logic               force_float
);
    localparam logic [31:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

    tap_state_e      state;
    logic [OP_W-1:0] ir_shift;
    logic [OP_W-1:0] ir_active;
    op_ctrl_t        ctrl;
    logic            chain_lsb;
    logic            dr_lsb;
    logic            byp_q;

    tap_fsm #(.RUN_LEN(RUN_LEN)) u_fsm (
        .tck   (tck),
        .por   (por),
        .tms   (tms),
        .tdi   (tdi),
        .state (state)
    );

    tap_ir u_ir (
        .tck       (tck),
        .por       (por),
        .state     (state),
        .tdi       (tdi),
        .ir_shift  (ir_shift),
        .ir_active (ir_active)
    );

    assign ctrl        = decode_op(ir_active);
    assign test_mode   = ctrl.test_mode;
    assign force_float = ctrl.force_float;

    tap_bsr #(.LEN(BSR_LEN)) u_bsr (
        .tck       (tck),
        .por       (por),
        .state     (state),
        .tdi       (tdi),
        .chain_sel (ctrl.sel == DR_CHAIN),
        .test_mode (ctrl.test_mode),
        .sys_in    (sys_in),
        .core_out  (core_out),
        .pin_out   (pin_out),
        .chain_lsb (chain_lsb)
    );

    tap_dr #(.ID_W(32), .ID_WORD(ID_WORD)) u_dr (
        .tck       (tck),
        .por       (por),
        .state     (state),
        .tdi       (tdi),
        .sel       (ctrl.sel),
        .chain_lsb (chain_lsb),
        .byp_q     (byp_q),
        .dr_lsb    (dr_lsb)
    );

    always_ff @(negedge tck) begin
        if (por) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
            if (state == ST_IR_SHIFT)      tdo <= ir_shift[0];
            else if (state == ST_DR_SHIFT) tdo <= dr_lsb;
        end
    end
endmodule

// File: rtl/tap_ctrl_chk.sv
`timescale 1ns/1ps
module tap_ctrl_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            por,
    input logic            tms,
    input logic            tdi,
    input tap_state_e      state,
    input logic [OP_W-1:0] ir_shift,
    input logic [OP_W-1:0] ir_active,
    input logic            byp_q,
    input logic            tdo_en,
    input logic            test_mode,
    input logic            force_float
);
    logic [2:0] hi_run;

    always_ff @(posedge tck) begin
        if (por || !(tms && tdi)) hi_run <= '0;
        else if (hi_run != 3'd7)  hi_run <= hi_run + 1'b1;
    end

    AST_POR_TO_RESET: assert property (@(posedge tck) por |=> state == ST_RESET); // R1
    AST_RESET_IDCODE: assert property (@(posedge tck) disable iff (por)
        state == ST_RESET |-> ir_active == OP_IDCODE); // R1
    AST_PIN_RUN_RESET: assert property (@(posedge tck) disable iff (por)
        (hi_run >= 3'd4 && tms && tdi) |=> state == ST_RESET); // R3
    AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (por)
        state == ST_IR_CAP |=> ir_shift == OP_CAPT_PAT); // R4
    AST_FLOAT_TEST_EXCL: assert property (@(posedge tck) disable iff (por)
        !(force_float && test_mode)); // R5
    AST_PASS_CAPTURE: assert property (@(posedge tck) disable iff (por)
        (state == ST_DR_CAP && ir_active == OP_BYPASS) |=> byp_q == 1'b0); // R7
    AST_TDO_WINDOW: assert property (@(posedge tck) disable iff (por)
        tdo_en == (state == ST_IR_SHIFT || state == ST_DR_SHIFT)); // R10
endmodule

bind tap_ctrl tap_ctrl_chk u_chk (
    .tck         (tck),
    .por         (por),
    .tms         (tms),
    .tdi         (tdi),
    .state       (state),
    .ir_shift    (ir_shift),
    .ir_active   (ir_active),
    .byp_q       (byp_q),
    .tdo_en      (tdo_en),
    .test_mode   (test_mode),
    .force_float (force_float)
);

// File: tb/sim_tap_ctrl.sv
`timescale 1ns/1ps
module sim_tap_ctrl;
    localparam int N = 8;
    localparam logic [31:0] EXP_ID = {4'h1, 16'h2626, 11'h001, 1'b1};

    localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                   S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                   S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;

    logic tck = 1'b0;
    logic por = 1'b1;
    logic tms = 1'b0;
    logic tdi = 1'b0;
    logic [N-1:0] sys_in = 8'hA5;
    logic [N-1:0] core_out = 8'h3C;
    logic tdo, tdo_en, test_mode, force_float;
    logic [N-1:0] pin_out;

    always #2.5 tck = ~tck;

    tap_ctrl u0 (
        .tck(tck), .por(por), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .sys_in(sys_in), .core_out(core_out), .pin_out(pin_out),
        .test_mode(test_mode), .force_float(force_float)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string tag = "R10";

    // reference model state
    int m_st = S_TLR;
    int m_run = 0;
    bit [3:0] m_irs = 0, m_ir = 4'b0001;
    bit m_byp = 0;
    bit [31:0] m_id = 0;
    bit [N-1:0] m_bsr = 0, m_hold = 0;
    bit m_en = 0, m_tdo = 0;

    function automatic int nxt(int s, bit t);
        case (s)
            S_TLR:  return t ? S_TLR  : S_RTI;
            S_RTI:  return t ? S_SDR  : S_RTI;
            S_SDR:  return t ? S_SIR  : S_CDR;
            S_CDR:  return t ? S_E1DR : S_SHDR;
            S_SHDR: return t ? S_E1DR : S_SHDR;
            S_E1DR: return t ? S_UDR  : S_PDR;
            S_PDR:  return t ? S_E2DR : S_PDR;
            S_E2DR: return t ? S_UDR  : S_SHDR;
            S_UDR:  return t ? S_SDR  : S_RTI;
            S_SIR:  return t ? S_TLR  : S_CIR;
            S_CIR:  return t ? S_E1IR : S_SHIR;
            S_SHIR: return t ? S_E1IR : S_SHIR;
            S_E1IR: return t ? S_UIR  : S_PIR;
            S_PIR:  return t ? S_E2IR : S_PIR;
            S_E2IR: return t ? S_UIR  : S_SHIR;
            default: return t ? S_SDR : S_RTI;
        endcase
    endfunction

    // 0 = pass-through, 1 = identification, 2 = pin chain
    function automatic int m_sel(bit [3:0] op);
        if (op == 4'b0000 || op == 4'b0010) return 2;
        if (op == 4'b0001) return 1;
        return 0;
    endfunction
    function automatic bit m_test(bit [3:0] op);
        return op == 4'b0000 || op == 4'b0100;
    endfunction

    always @(posedge tck) begin
        if (por) begin
            m_st = S_TLR; m_run = 0; m_irs = 0; m_byp = 0; m_id = 0; m_bsr = 0;
        end else begin
            if (m_st == S_CIR) m_irs = 4'b0001;
            if (m_st == S_SHIR) m_irs = {tdi, m_irs[3:1]};
            if (m_st == S_CDR) begin
                case (m_sel(m_ir))
                    0: m_byp = 0;
                    1: m_id = EXP_ID;
                    default: m_bsr = sys_in;
                endcase
            end
            if (m_st == S_SHDR) begin
                case (m_sel(m_ir))
                    0: m_byp = tdi;
                    1: m_id = {tdi, m_id[31:1]};
                    default: m_bsr = {tdi, m_bsr[N-1:1]};
                endcase
            end
            if (tms && tdi) begin
                m_run++;
                if (m_run == 5) begin m_st = S_TLR; m_run = 0; end
                else m_st = nxt(m_st, tms);
            end else begin
                m_run = 0;
                m_st = nxt(m_st, tms);
            end
        end
    end

    always @(negedge tck) begin
        if (por) begin
            m_ir = 4'b0001; m_en = 0; m_tdo = 0; m_hold = 0;
        end else begin
            if (m_st == S_TLR) m_ir = 4'b0001;
            else if (m_st == S_UIR) m_ir = m_irs;
            if (m_st == S_UDR && m_sel(m_ir) == 2) m_hold = m_bsr;
            m_en = (m_st == S_SHIR || m_st == S_SHDR);
            if (m_st == S_SHIR) m_tdo = m_irs[0];
            else if (m_st == S_SHDR) begin
                case (m_sel(m_ir))
                    0: m_tdo = m_byp;
                    1: m_tdo = m_id[0];
                    default: m_tdo = m_bsr[0];
                endcase
            end
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R10", 64'(tdo_en), 64'(m_en));
        if (m_en) chk(tag, 64'(tdo), 64'(m_tdo));
        chk("R5", 64'(test_mode), 64'(m_test(m_ir)));
        chk("R5", 64'(force_float), 64'(m_ir == 4'b0011));
        chk("R9", 64'(pin_out), 64'(m_test(m_ir) ? m_hold : core_out));
    endtask

    task automatic step(bit t, bit d);
        tms = t;
        tdi = d;
        @(negedge tck);
        #1;
        compare();
    endtask

    // from Run-Test/Idle back to Run-Test/Idle (R2, R4)
    task automatic load_ir(bit [3:0] code);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        tag = "R4";
        for (int i = 0; i < 4; i++) step(i == 3, code[i]);
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(int n, bit [63:0] din, output bit [63:0] dout, input string t);
        dout = 0;
        step(1, 0); step(0, 0); step(0, 0);
        tag = t;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            step(i == n - 1, din[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    initial begin
        bit [63:0] got;
        repeat (3) @(negedge tck);
        #1;
        // R1: reset state
        chk("R1", 64'(tdo_en), 64'd0);
        chk("R1", 64'(test_mode), 64'd0);
        chk("R1", 64'(force_float), 64'd0);
        por = 1'b0;
        step(0, 0);
        // R8 and R1: IDCODE is active after reset
        scan_dr(32, 64'hFFFF_FFFF, got, "R8");
        chk("R8", got[31:0], EXP_ID);
        // R4: the capture pattern shifts out while an instruction is loaded
        load_ir(4'b1111);
        // R7: pass-through delays data by one shift
        scan_dr(8, 64'h00B6, got, "R7");
        chk("R7", got[7:0], 8'h6C);
        // R6: a reserved code behaves like the pass-through instruction
        load_ir(4'b0110);
        chk("R6", 64'(test_mode), 64'd0);
        chk("R6", 64'(force_float), 64'd0);
        scan_dr(8, 64'h0053, got, "R6");
        chk("R6", got[7:0], 8'hA6);
        // R9: SAMPLE captures pins, pads keep core values
        load_ir(4'b0010);
        scan_dr(N, 64'h0081, got, "R9");
        chk("R9", got[N-1:0], 8'hA5);
        chk("R9", 64'(pin_out), 64'(core_out));
        // R9/R5: EXTEST drives the hold stages onto the pads
        load_ir(4'b0000);
        chk("R5", 64'(test_mode), 64'd1);
        sys_in = 8'h5A;
        scan_dr(N, 64'h00E7, got, "R9");
        chk("R9", got[N-1:0], 8'h5A);
        chk("R9", 64'(pin_out), 64'hE7);
        // R5: float with pass-through
        load_ir(4'b0011);
        chk("R5", 64'(force_float), 64'd1);
        chk("R5", 64'(test_mode), 64'd0);
        // R5: test mode with pass-through
        load_ir(4'b0100);
        chk("R5", 64'(test_mode), 64'd1);
        scan_dr(4, 64'h000F, got, "R5");
        chk("R5", got[3:0], 4'hE);
        // R3: five edges with tms and tdi both high
        load_ir(4'b0000);
        chk("R3", 64'(test_mode), 64'd1);
        for (int i = 0; i < 5; i++) step(1, 1);
        chk("R3", 64'(test_mode), 64'd0);
        step(0, 0);
        scan_dr(32, 64'h0, got, "R3");
        chk("R3", got[31:0], EXP_ID);
        // R2: pause states keep shift register contents
        load_ir(4'b0001);
        step(1, 0); step(0, 0); step(1, 0); step(0, 0); step(0, 0);
        step(1, 0); step(0, 0);
        tag = "R2";
        chk("R2", 64'(tdo_en), 64'd1);
        chk("R2", 64'(tdo), 64'(EXP_ID[0]));
        step(1, 0); step(1, 0); step(0, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge tck);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule